// File: doc/BRIEF.md
# Audio FIFO Threshold and Interrupt Unit

This block watches the fill levels of an audio transmit FIFO and an audio receive FIFO, each 32 words of 32 bits, and turns them into single-word DMA requests, a readable pair of available counts and an 8-bit set of sticky interrupt flags. The FIFO storage and the serial audio logic sit outside this block. The unit only sees each FIFO's current fill level, one-cycle overflow and underflow pulses, and a DMA error pulse for each direction.

Software reaches the unit through a small register port: a configuration word holding a 4-bit threshold per direction, the flag register (cleared by writing ones), an 8-bit interrupt enable mask and a read-only level word. The interrupt line is high while any enabled flag is set. Each DMA request moves one word. The request is a valid signal that the DMA engine acknowledges with ready. A request stays up until it is accepted or until the fill level changes. After an accepted transfer the request drops for one cycle, so that the FIFO level can catch up before another word is asked for.

Top module: `audio_fifo_irq`

## Requirements
- R1: While reset is asserted and after its release, the configuration word reads 0x0000_4040, the flag register and the enable mask read 0, and `irq` is low.
- R2: The configuration word sits at address 0. The receive threshold is bits [15:12] and the transmit threshold is bits [7:4]. All other bits read as 0. A write replaces both fields.
- R3: Flag bit 0 (transmit threshold) is set at every clock edge where `tx_level` is strictly below the transmit threshold. A level equal to the threshold does not set it.
- R4: Flag bit 4 (receive threshold) is set at every clock edge where `rx_level` is greater than or equal to the receive threshold.
- R5: Pulses sampled at a clock edge set the flags as follows: transmit underrun sets bit 1, transmit overrun sets bit 2 and transmit DMA fault sets bit 3. Receive underrun, overrun and fault set bits 5, 6 and 7.
- R6: The flag register is at address 1. Writing a one to a bit clears that flag, writing a zero leaves it alone, and a flag with no clear pending keeps its value.
- R7: When hardware sets a flag in the same cycle that software writes a one to clear it, the flag stays set.
- R8: The enable mask is 8 bits wide at address 2, and writing 0xFF enables all flags. `irq` is high exactly when some flag bit and the matching enable bit are both 1.
- R9: The level word at address 3 is read-only. Bits [5:0] hold the transmit free space (32 minus `tx_level`) and bits [13:8] hold `rx_level`. Writes to it change nothing.
- R10: `tx_dma_valid` is high while `tx_level` < 32, and `rx_dma_valid` is high while `rx_level` > 0. Each handshake (valid and ready at one edge) moves one word and forces the request low for the next cycle. A request that is not accepted stays high while the level holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_level | input | 6 | Transmit FIFO fill level, 0 to 32 |
| rx_level | input | 6 | Receive FIFO fill level, 0 to 32 |
| tx_underrun | input | 1 | Transmit underrun pulse |
| tx_overrun | input | 1 | Transmit overrun pulse |
| tx_dma_fault | input | 1 | Transmit DMA error pulse |
| rx_underrun | input | 1 | Receive underrun pulse |
| rx_overrun | input | 1 | Receive overrun pulse |
| rx_dma_fault | input | 1 | Receive DMA error pulse |
| reg_addr | input | 2 | Register address (0 config, 1 flags, 2 enable, 3 levels) |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, same cycle |
| irq | output | 1 | Combined masked interrupt |
| tx_dma_valid | output | 1 | Transmit single-word DMA request |
| tx_dma_ready | input | 1 | Transmit request accepted |
| rx_dma_valid | output | 1 | Receive single-word DMA request |
| rx_dma_ready | input | 1 | Receive request accepted |

## Verification
A hardware flag set can fall in the same cycle as a software write-one clear of the same bit. The stimulus table provokes this in two ways: it writes a clear for a bit while an event pulse for that bit is applied, and it clears both threshold flags while the levels still meet their thresholds. After that edge the flag register is read back and the flag must still be set, while neighbouring bits cleared in the same write must read 0. The DMA handshake and a changing level also share cycles. This is judged by checking the one-cycle request gap after an accepted word and the held request while ready stays low.

// File: rtl/afiq_pkg.sv
package afiq_pkg;
  localparam int FLAG_W       = 8;
  localparam int DIR_FLAGS    = 4;
  localparam int RX_FLAG_BASE = 4;
  localparam int TX_THR_LSB   = 4;
  localparam int RX_THR_LSB   = 12;
  localparam int RX_AVL_LSB   = 8;
  localparam logic [3:0] THR_RESET = 4'd4;

  typedef enum logic [1:0] {
    ADDR_CFG  = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_IEN  = 2'd2,
    ADDR_LVL  = 2'd3
  } reg_addr_e;

  // bit 0 threshold, 1 underrun, 2 overrun, 3 fault
  typedef struct packed {
    logic flt;
    logic ovf;
    logic unf;
    logic thr;
  } dir_evt_t;
endpackage

// File: rtl/afiq_dir_mon.sv
module afiq_dir_mon
  import afiq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LVL_W = 6,
  parameter int THR_W = 4,
  parameter bit IS_RX = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [THR_W-1:0] thr,
  input  logic             unf_pulse,
  input  logic             ovf_pulse,
  input  logic             flt_pulse,
  input  logic             dma_ready,
  output dir_evt_t         evt,
  output logic [LVL_W-1:0] avail,
  output logic             dma_valid
);
  localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);

  logic [LVL_W-1:0] thr_ext;
  logic             cond;
  logic             base_req;
  logic             gap_q;

  assign thr_ext = LVL_W'(thr);

  generate
    if (IS_RX) begin : g_rx
      assign cond     = (level >= thr_ext);
      assign base_req = (level != '0);
      assign avail    = (level > DEPTH_L) ? DEPTH_L : level;
    end else begin : g_tx
      assign cond     = (level < thr_ext);
      assign base_req = (level < DEPTH_L);
      assign avail    = (level >= DEPTH_L) ? '0 : (DEPTH_L - level);
    end
  endgenerate

  always_comb begin
    evt     = '0;
    evt.thr = cond;
    evt.unf = unf_pulse;
    evt.ovf = ovf_pulse;
    evt.flt = flt_pulse;
  end

  // one idle cycle after each accepted word lets the FIFO level settle
  always_ff @(posedge clk) begin
    if (!rst_n) gap_q <= 1'b0;
    else        gap_q <= dma_valid && dma_ready;
  end

  assign dma_valid = base_req && !gap_q;

  AST_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_valid && dma_ready) |=> !dma_valid); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_valid && !dma_ready) |=> (dma_valid || (level != $past(level)))); // R10
endmodule

// File: rtl/afiq_flag_bank.sv
module afiq_flag_bank #(
  parameter int FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] set_vec,
  input  logic              clr_we,
  input  logic [FLAG_W-1:0] clr_mask,
  input  logic              ien_we,
  input  logic [FLAG_W-1:0] ien_wdata,
  output logic [FLAG_W-1:0] status,
  output logic [FLAG_W-1:0] ien,
  output logic              irq
);
  logic [FLAG_W-1:0] status_q;
  logic [FLAG_W-1:0] ien_q;
  logic [FLAG_W-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_mask : '0;

  // hardware set is applied after the clear, so it wins on a collision
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      ien_q    <= '0;
    end else begin
      status_q <= (status_q & ~clr_eff) | set_vec;
      if (ien_we) ien_q <= ien_wdata;
    end
  end

  assign status = status_q;
  assign ien    = ien_q;
  assign irq    = |(status_q & ien_q);

  generate
    for (genvar i = 0; i < FLAG_W; i++) begin : g_chk
      AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[i] |=> status_q[i]); // R7
      AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[i] && !(clr_we && clr_mask[i])) |=> status_q[i]); // R6
      AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_mask[i] && !set_vec[i]) |=> !status_q[i]); // R6
    end
  endgenerate

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq); // R8
endmodule

// File: rtl/afiq_regs.sv
module afiq_regs
  import afiq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int THR_W  = 4,
  parameter int LVL_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [FLAG_W-1:0] status,
  input  logic [FLAG_W-1:0] ien,
  input  logic [LVL_W-1:0]  tx_avail,
  input  logic [LVL_W-1:0]  rx_avail,
  output logic [THR_W-1:0]  tx_thr,
  output logic [THR_W-1:0]  rx_thr,
  output logic              stat_clr_we,
  output logic              ien_we,
  output logic [FLAG_W-1:0] flag_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  reg_addr_e        addr_e;
  logic             cfg_we;
  logic [THR_W-1:0] tx_thr_q;
  logic [THR_W-1:0] rx_thr_q;
  logic             unused_wbits;

  assign addr_e      = reg_addr_e'(reg_addr);
  assign cfg_we      = reg_we && (addr_e == ADDR_CFG);
  assign stat_clr_we = reg_we && (addr_e == ADDR_STAT);
  assign ien_we      = reg_we && (addr_e == ADDR_IEN);
  assign flag_wdata  = reg_wdata[FLAG_W-1:0];
  assign unused_wbits = ^{reg_wdata[DATA_W-1:RX_THR_LSB+THR_W],
                          reg_wdata[RX_THR_LSB-1:FLAG_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_thr_q <= THR_W'(THR_RESET);
      rx_thr_q <= THR_W'(THR_RESET);
    end else if (cfg_we) begin
      tx_thr_q <= reg_wdata[TX_THR_LSB +: THR_W];
      rx_thr_q <= reg_wdata[RX_THR_LSB +: THR_W];
    end
  end

  assign tx_thr = tx_thr_q;
  assign rx_thr = rx_thr_q;

  always_comb begin
    reg_rdata = '0;
    unique case (addr_e)
      ADDR_CFG: begin
        reg_rdata[TX_THR_LSB +: THR_W] = tx_thr_q;
        reg_rdata[RX_THR_LSB +: THR_W] = rx_thr_q;
      end
      ADDR_STAT: reg_rdata[FLAG_W-1:0] = status;
      ADDR_IEN:  reg_rdata[FLAG_W-1:0] = ien;
      ADDR_LVL: begin
        reg_rdata[0 +: LVL_W]          = tx_avail;
        reg_rdata[RX_AVL_LSB +: LVL_W] = rx_avail;
      end
      default: reg_rdata = '0;
    endcase
  end

  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(tx_thr_q) && $stable(rx_thr_q))); // R2
endmodule

// File: rtl/audio_fifo_irq.sv
module audio_fifo_irq
  import afiq_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 32,
  parameter int THR_W  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [$clog2(DEPTH+1)-1:0]   tx_level,
  input  logic [$clog2(DEPTH+1)-1:0]   rx_level,
  input  logic                         tx_underrun,
  input  logic                         tx_overrun,
  input  logic                         tx_dma_fault,
  input  logic                         rx_underrun,
  input  logic                         rx_overrun,
  input  logic                         rx_dma_fault,
  input  logic [1:0]                   reg_addr,
  input  logic                         reg_we,
  input  logic [DATA_W-1:0]            reg_wdata,
  output logic [DATA_W-1:0]            reg_rdata,
  output logic                         irq,
  output logic                         tx_dma_valid,
  input  logic                         tx_dma_ready,
  output logic                         rx_dma_valid,
  input  logic                         rx_dma_ready
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  dir_evt_t          tx_evt;
  dir_evt_t          rx_evt;
  logic [LVL_W-1:0]  tx_avail;
  logic [LVL_W-1:0]  rx_avail;
  logic [THR_W-1:0]  tx_thr;
  logic [THR_W-1:0]  rx_thr;
  logic              stat_clr_we;
  logic              ien_we;
  logic [FLAG_W-1:0] flag_wdata;
  logic [FLAG_W-1:0] status;
  logic [FLAG_W-1:0] ien;
  logic [FLAG_W-1:0] set_vec;

  afiq_dir_mon #(.DEPTH(DEPTH), .LVL_W(LVL_W), .THR_W(THR_W), .IS_RX(1'b0)) u_tx_mon (
    .clk(clk), .rst_n(rst_n), .level(tx_level), .thr(tx_thr),
    .unf_pulse(tx_underrun), .ovf_pulse(tx_overrun), .flt_pulse(tx_dma_fault),
    .dma_ready(tx_dma_ready), .evt(tx_evt), .avail(tx_avail), .dma_valid(tx_dma_valid)
  );

  afiq_dir_mon #(.DEPTH(DEPTH), .LVL_W(LVL_W), .THR_W(THR_W), .IS_RX(1'b1)) u_rx_mon (
    .clk(clk), .rst_n(rst_n), .level(rx_level), .thr(rx_thr),
    .unf_pulse(rx_underrun), .ovf_pulse(rx_overrun), .flt_pulse(rx_dma_fault),
    .dma_ready(rx_dma_ready), .evt(rx_evt), .avail(rx_avail), .dma_valid(rx_dma_valid)
  );

  // receive nibble above transmit nibble
  assign set_vec = {rx_evt, tx_evt};

  afiq_flag_bank #(.FLAG_W(FLAG_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
    .clr_we(stat_clr_we), .clr_mask(flag_wdata),
    .ien_we(ien_we), .ien_wdata(flag_wdata),
    .status(status), .ien(ien), .irq(irq)
  );

  afiq_regs #(.DATA_W(DATA_W), .THR_W(THR_W), .LVL_W(LVL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .status(status), .ien(ien),
    .tx_avail(tx_avail), .rx_avail(rx_avail), .tx_thr(tx_thr), .rx_thr(rx_thr),
    .stat_clr_we(stat_clr_we), .ien_we(ien_we), .flag_wdata(flag_wdata),
    .reg_rdata(reg_rdata)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (status == '0 && !irq)); // R1
endmodule

// File: tb/audio_fifo_irq_tb_top.sv
module audio_fifo_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  tx_level, rx_level;
  logic        tx_underrun, tx_overrun, tx_dma_fault;
  logic        rx_underrun, rx_overrun, rx_dma_fault;
  logic [1:0]  reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq, tx_dma_valid, tx_dma_ready, rx_dma_valid, rx_dma_ready;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  audio_fifo_irq dut_i (
    .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
    .tx_underrun(tx_underrun), .tx_overrun(tx_overrun), .tx_dma_fault(tx_dma_fault),
    .rx_underrun(rx_underrun), .rx_overrun(rx_overrun), .rx_dma_fault(rx_dma_fault),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .tx_dma_valid(tx_dma_valid), .tx_dma_ready(tx_dma_ready),
    .rx_dma_valid(rx_dma_valid), .rx_dma_ready(rx_dma_ready)
  );

  // {tx_level, rx_level, events, clear mask, expected flags}
  // events: [5] tx unf [4] tx ovf [3] tx flt [2] rx unf [1] rx ovf [0] rx flt
  localparam logic [33:0] VEC [0:13] = '{
    {6'd16, 6'd0,  6'b000000, 8'h00, 8'h00},  // idle
    {6'd3,  6'd0,  6'b000000, 8'h00, 8'h01},  // R3 below tx threshold
    {6'd16, 6'd0,  6'b000000, 8'h01, 8'h00},  // R6 clear
    {6'd16, 6'd4,  6'b000000, 8'h00, 8'h10},  // R4 rx at threshold
    {6'd16, 6'd3,  6'b100000, 8'h00, 8'h12},  // R5 tx underrun
    {6'd16, 6'd3,  6'b000010, 8'h10, 8'h42},  // R5 rx overrun, R6 clear bit4
    {6'd16, 6'd3,  6'b011000, 8'h02, 8'h4C},  // R5 tx ovf+fault
    {6'd16, 6'd3,  6'b000101, 8'h00, 8'hEC},  // R5 rx unf+fault
    {6'd16, 6'd3,  6'b100000, 8'h02, 8'hEE},  // R7 set beats clear
    {6'd2,  6'd32, 6'b000000, 8'h11, 8'hFF},  // R7 thresholds beat clear
    {6'd16, 6'd0,  6'b000000, 8'hFF, 8'h00},  // R6 clear all
    {6'd4,  6'd0,  6'b000000, 8'h00, 8'h00},  // R3 equal is not below
    {6'd16, 6'd31, 6'b000000, 8'h00, 8'h10},  // R4 above threshold
    {6'd32, 6'd0,  6'b000000, 8'hFF, 8'h00}   // R6 clear
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    tick();
    reg_we    = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0;
    tx_level = 6'd16; rx_level = 6'd0;
    {tx_underrun, tx_overrun, tx_dma_fault} = '0;
    {rx_underrun, rx_overrun, rx_dma_fault} = '0;
    reg_addr = 2'd0; reg_we = 1'b0; reg_wdata = '0;
    tx_dma_ready = 1'b0; rx_dma_ready = 1'b0;
    @(negedge clk);
    repeat (3) tick();

    // R1 reset state
    rd(2'd0, v); chk("R1 cfg", v, 32'h0000_4040);
    rd(2'd1, v); chk("R1 flags", v, 32'h0);
    rd(2'd2, v); chk("R1 enable", v, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    tick();
    rd(2'd1, v); chk("R1 flags after release", v, 32'h0);

    // table walk
    for (int i = 0; i < 14; i++) begin
      tx_level = VEC[i][33:28];
      rx_level = VEC[i][27:22];
      {tx_underrun, tx_overrun, tx_dma_fault, rx_underrun, rx_overrun, rx_dma_fault} = VEC[i][21:16];
      reg_addr  = 2'd1;
      reg_wdata = {24'd0, VEC[i][15:8]};
      reg_we    = (VEC[i][15:8] != 8'h00);
      tick();
      {tx_underrun, tx_overrun, tx_dma_fault, rx_underrun, rx_overrun, rx_dma_fault} = '0;
      reg_we = 1'b0;
      rd(2'd1, v);
      chk($sformatf("R3-R7 vector %0d flags", i), v, {24'd0, VEC[i][7:0]});
    end

    // R2 configuration fields
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); chk("R2 unused bits read zero", v, 32'h0000_F0F0);
    wr(2'd0, 32'h0000_2080);
    tx_level = 6'd7;
    tick();
    rd(2'd1, v); chk("R3 programmed tx threshold 8", v, 32'h01);
    tx_level = 6'd8; rx_level = 6'd2;
    wr(2'd1, 32'hFF);
    rd(2'd1, v); chk("R4 programmed rx threshold 2", v, 32'h10);
    rx_level = 6'd1;
    wr(2'd1, 32'hFF);
    rd(2'd1, v); chk("R6 clear after condition gone", v, 32'h00);
    wr(2'd0, 32'h0000_4040);
    tx_level = 6'd16; rx_level = 6'd0;

    // R8 enable mask and irq
    rx_overrun = 1'b1;
    tick();
    rx_overrun = 1'b0;
    rd(2'd1, v); chk("R5 rx overrun bit6", v, 32'h40);
    chk("R8 irq masked", {31'd0, irq}, 32'd0);
    wr(2'd2, 32'h40);
    chk("R8 irq enabled bit", {31'd0, irq}, 32'd1);
    wr(2'd2, 32'hBF);
    chk("R8 irq other bits only", {31'd0, irq}, 32'd0);
    wr(2'd2, 32'h1FF);
    rd(2'd2, v); chk("R8 enable width", v, 32'hFF);
    chk("R8 all enabled", {31'd0, irq}, 32'd1);
    wr(2'd1, 32'h40);
    chk("R8 irq drops after clear", {31'd0, irq}, 32'd0);

    // R9 level word
    tx_level = 6'd10; rx_level = 6'd7;
    rd(2'd3, v); chk("R9 levels", v, 32'h0000_0716);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v); chk("R9 write ignored", v, 32'h0000_0716);
    rd(2'd0, v); chk("R9 write leaves cfg", v, 32'h0000_4040);
    tx_level = 6'd32; rx_level = 6'd32;
    rd(2'd3, v); chk("R9 full levels", v, 32'h0000_2000);

    // R10 DMA requests
    tx_level = 6'd31; rx_level = 6'd0;
    tick();
    #1;
    chk("R10 tx request with space", {31'd0, tx_dma_valid}, 32'd1);
    chk("R10 rx no request when empty", {31'd0, rx_dma_valid}, 32'd0);
    tx_dma_ready = 1'b1;
    tick();
    tx_dma_ready = 1'b0;
    #1;
    chk("R10 tx gap after word", {31'd0, tx_dma_valid}, 32'd0);
    tick();
    #1;
    chk("R10 tx request returns", {31'd0, tx_dma_valid}, 32'd1);
    tx_level = 6'd32;
    #1;
    chk("R10 tx no request when full", {31'd0, tx_dma_valid}, 32'd0);
    rx_level = 6'd1;
    #1;
    chk("R10 rx request with data", {31'd0, rx_dma_valid}, 32'd1);
    repeat (3) tick();
    #1;
    chk("R10 rx held without ready", {31'd0, rx_dma_valid}, 32'd1);
    rx_dma_ready = 1'b1;
    tick();
    rx_dma_ready = 1'b0;
    #1;
    chk("R10 rx gap after word", {31'd0, rx_dma_valid}, 32'd0);

    summary();
    $finish;
  end
endmodule